// File: doc/BRIEF.md
# External Interrupt Exception Entry Controller

This block decides, one instruction boundary at a time, whether a level-sensitive external interrupt request is accepted, and it produces the architectural state update for exception entry. It looks at the request level only when the core signals an instruction boundary, and only while the external-enable bit of the current 32-bit machine state word is set. It never latches the request. A request that drops before a boundary is simply lost.

On acceptance the block captures the next-instruction address and the low half of the machine state into two save registers. It presents a rewritten machine state word with a write strobe, and it redirects fetch to the handler vector. The vector is offset 0x500 from a base that a prefix bit of the machine state selects. A return-from-interrupt input reverses the entry: it restores the low half of the machine state from the second save register and redirects fetch to the address held in the first save register. The machine state register itself lives outside the block. The block only reads it and proposes the next value.

Top module: `xirq_entry_ctrl`

## Requirements
- R1: A request is accepted only when `state_i[15]` (external enable, big-endian bit 16) is 1. While it is 0, `take_o`, `redirect_o` and `state_we_o` stay 0 and both save registers keep their contents.
- R2: The request level is sampled only in a cycle where `boundary_i` is 1. A request without a boundary, or a boundary without a request, causes no entry, because nothing is latched.
- R3: One cycle after acceptance, `take_o` and `redirect_o` are 1 and `redirect_addr_o` is 0x00000500 when `state_i[6]` (prefix bit, big-endian bit 25) was 0, or 0xFFF00500 when it was 1.
- R4: On entry, `save_pc_o` takes the value `next_pc_i` had in the accepting cycle.
- R5: On entry, `save_state_o[31:16]` is 0 and `save_state_o[15:0]` is a copy of `state_i[15:0]` (big-endian bits 16 to 31).
- R6: On entry, `state_we_o` is 1 and `state_new_o[0]` (little-endian) equals the old `state_i[16]` (interrupt little-endian). Indices 15, 14 and 13 (external enable, problem state, FP available) are 0.
- R7: On entry, indices 18, 17, 11, 10, 9, 8, 5, 4 and 1 of `state_new_o` are 0. All other bits, including 16, 12 and 6, keep their old values.
- R8: `take_o` lasts one cycle. After an entry, no further entry happens until `state_i[15]` has been seen at 0 in some cycle and is set again.
- R9: A return (`rfi_i` = 1) gives, one cycle later, `redirect_o` = 1, `redirect_addr_o` = `save_pc_o`, `state_we_o` = 1, `take_o` = 0 and `state_new_o` = {`state_i[31:16]`, `save_state_o[15:0]`}. A return wins over a request in the same cycle.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 1 | External interrupt request level |
| boundary_i | input | 1 | Instruction boundary strobe |
| rfi_i | input | 1 | Return-from-interrupt request |
| state_i | input | 32 | Current machine state word |
| next_pc_i | input | 32 | Address of the next instruction to execute |
| take_o | output | 1 | One-cycle interrupt-taken pulse |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_addr_o | output | 32 | Fetch redirect target |
| state_we_o | output | 1 | Machine state write strobe |
| state_new_o | output | 32 | Machine state value to write |
| save_pc_o | output | 32 | First save register (return address) |
| save_state_o | output | 32 | Second save register (saved state) |

## Verification
The assertions assume that the external machine state register applies `state_new_o` whenever `state_we_o` pulses. They also assume that, after an entry, the external-enable bit is reported low at least once before it is set again, because the re-arm in R8 depends on that. The stimulus meets these assumptions by inserting an idle cycle with a cleared state word after every entry. It also holds a stale enable bit high on purpose only in the back-to-back test. Returns are issued only after an entry has filled the save registers, so the restore values always come from a known capture.

// File: rtl/xirq_pkg.sv
// Package: shared field positions and constants for the external interrupt
// entry controller. Index values are positions in a [31:0] vector, where
// big-endian bit n sits at index 31-n. Neighbouring logic decodes these
// positions, so they are fixed.
package xirq_pkg;

    localparam int unsigned STATE_W = 32;
    localparam int unsigned HALF_W  = STATE_W / 2;

    // Machine state field indices
    localparam int unsigned IX_POWER  = 18;
    localparam int unsigned IX_GPRSW  = 17;
    localparam int unsigned IX_ILE    = 16;
    localparam int unsigned IX_EE     = 15;
    localparam int unsigned IX_PRIV   = 14;
    localparam int unsigned IX_FPU    = 13;
    localparam int unsigned IX_MCHK   = 12;
    localparam int unsigned IX_FPX0   = 11;
    localparam int unsigned IX_STEP   = 10;
    localparam int unsigned IX_BRTR   = 9;
    localparam int unsigned IX_FPX1   = 8;
    localparam int unsigned IX_PREFIX = 6;
    localparam int unsigned IX_IXLAT  = 5;
    localparam int unsigned IX_DXLAT  = 4;
    localparam int unsigned IX_RECOV  = 1;
    localparam int unsigned IX_LE     = 0;

    // Indices cleared on entry (the little-endian bit is then reloaded)
    localparam int unsigned N_CLR = 13;
    localparam int unsigned CLR_LIST [N_CLR] = '{
        IX_POWER, IX_GPRSW, IX_EE, IX_PRIV, IX_FPU, IX_FPX0, IX_STEP,
        IX_BRTR, IX_FPX1, IX_IXLAT, IX_DXLAT, IX_RECOV, IX_LE
    };

    // Build the clear mask from the list.
    function automatic logic [STATE_W-1:0] entry_clear_mask();
        logic [STATE_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_CLR; i++) begin
            m[CLR_LIST[i]] = 1'b1;
        end
        return m;
    endfunction

    // Kind of state update issued in a cycle
    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_ENTRY  = 2'd1,
        UPD_RETURN = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/xirq_accept.sv
// Module: xirq_accept
// Decides acceptance of the level-sensitive external request. The request
// is looked at only in boundary cycles, and nothing is latched. After an
// entry, a re-arm flag blocks a second entry until the enable bit has been
// observed low. This covers the cycle in which the external state register
// still shows the stale enable.
// Assumes: the state register applies the entry update one cycle after take.
module xirq_accept (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic boundary_i,
    input  logic ee_i,
    input  logic rfi_i,
    output logic accept_o
);

    logic blocked_q;

    // Acceptance: boundary, live request, enabled, armed, and no return pending.
    always_comb begin
        accept_o = boundary_i & irq_i & ee_i & ~blocked_q & ~rfi_i;
    end

    // Re-arm flag: set by an entry, cleared once the enable is seen low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
        end else if (accept_o) begin
            blocked_q <= 1'b1;
        end else if (!ee_i) begin
            blocked_q <= 1'b0;
        end
    end

    AST_BLOCK_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o); // R8

endmodule

// File: rtl/xirq_state_xform.sv
// Module: xirq_state_xform
// Pure combinational view of the state rewrites. It gives the entry value
// (selected fields cleared, little-endian loaded from the interrupt-endian
// bit), the return value (low half taken from the saved copy) and the
// handler vector, whose base the prefix bit selects.
// Assumes: the inputs are stable within the cycle.
module xirq_state_xform
    import xirq_pkg::*;
#(
    parameter logic [STATE_W-1:0] VEC_OFFSET = 32'h0000_0500,
    parameter logic [STATE_W-1:0] BASE_LOW   = 32'h0000_0000,
    parameter logic [STATE_W-1:0] BASE_HIGH  = 32'hFFF0_0000
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [STATE_W-1:0] saved_state_i,
    output logic [STATE_W-1:0] entry_state_o,
    output logic [STATE_W-1:0] return_state_o,
    output logic [STATE_W-1:0] save_image_o,
    output logic [STATE_W-1:0] vector_o
);

    localparam logic [STATE_W-1:0] CLR_MASK = entry_clear_mask();

    // Entry rewrite: clear the selected fields, then copy ILE into LE.
    always_comb begin
        entry_state_o        = state_i & ~CLR_MASK;
        entry_state_o[IX_LE] = state_i[IX_ILE];
    end

    // Return rewrite: keep the upper half, restore the lower half.
    always_comb begin
        return_state_o = {state_i[STATE_W-1:HALF_W], saved_state_i[HALF_W-1:0]};
    end

    // Image stored in the second save register: the upper half is zeroed.
    always_comb begin
        save_image_o = {{HALF_W{1'b0}}, state_i[HALF_W-1:0]};
    end

    // Handler vector: the base chosen by the prefix bit, plus the fixed offset.
    always_comb begin
        vector_o = (state_i[IX_PREFIX] ? BASE_HIGH : BASE_LOW) | VEC_OFFSET;
    end

    always_comb begin
        AST_ENTRY_DROPS_EE: assert (!entry_state_o[IX_EE] && !entry_state_o[IX_PRIV]); // R6
    end

endmodule

// File: rtl/xirq_save_bank.sv
// Module: xirq_save_bank
// Holds the two save registers. Both load together when an entry is issued
// and hold their contents at all other times. A return only reads them.
// Assumes: load_i is high for one cycle per entry.
module xirq_save_bank
    import xirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [STATE_W-1:0] pc_d_i,
    input  logic [STATE_W-1:0] state_d_i,
    output logic [STATE_W-1:0] pc_q_o,
    output logic [STATE_W-1:0] state_q_o
);

    // Save registers: capture on entry, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q_o    <= '0;
            state_q_o <= '0;
        end else if (load_i) begin
            pc_q_o    <= pc_d_i;
            state_q_o <= state_d_i;
        end
    end

    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> ($stable(pc_q_o) && $stable(state_q_o))); // R1

endmodule

// File: rtl/xirq_entry_ctrl.sv
// Module: xirq_entry_ctrl (top)
// External interrupt entry controller. It combines acceptance, the state
// rewrites and the save registers, and it registers the control outputs so
// that take, redirect and state write appear one cycle after the deciding
// boundary. A return has priority over a request in the same cycle.
// Assumes: the machine state register is external and applies state_new_o
// when state_we_o is high.
module xirq_entry_ctrl
    import xirq_pkg::*;
#(
    parameter logic [31:0] VEC_OFFSET = 32'h0000_0500,
    parameter logic [31:0] BASE_LOW   = 32'h0000_0000,
    parameter logic [31:0] BASE_HIGH  = 32'hFFF0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_i,
    input  logic        boundary_i,
    input  logic        rfi_i,
    input  logic [31:0] state_i,
    input  logic [31:0] next_pc_i,
    output logic        take_o,
    output logic        redirect_o,
    output logic [31:0] redirect_addr_o,
    output logic        state_we_o,
    output logic [31:0] state_new_o,
    output logic [31:0] save_pc_o,
    output logic [31:0] save_state_o
);

    logic               accept;
    upd_kind_e          kind;
    logic [STATE_W-1:0] entry_state;
    logic [STATE_W-1:0] return_state;
    logic [STATE_W-1:0] save_image;
    logic [STATE_W-1:0] vector;

    xirq_accept u_accept (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_i),
        .boundary_i (boundary_i),
        .ee_i       (state_i[IX_EE]),
        .rfi_i      (rfi_i),
        .accept_o   (accept)
    );

    xirq_state_xform #(
        .VEC_OFFSET (VEC_OFFSET),
        .BASE_LOW   (BASE_LOW),
        .BASE_HIGH  (BASE_HIGH)
    ) u_xform (
        .state_i        (state_i),
        .saved_state_i  (save_state_o),
        .entry_state_o  (entry_state),
        .return_state_o (return_state),
        .save_image_o   (save_image),
        .vector_o       (vector)
    );

    xirq_save_bank u_save (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .pc_d_i    (next_pc_i),
        .state_d_i (save_image),
        .pc_q_o    (save_pc_o),
        .state_q_o (save_state_o)
    );

    // Classify the update for this cycle; a return wins over an entry.
    always_comb begin
        if (rfi_i) begin
            kind = UPD_RETURN;
        end else if (accept) begin
            kind = UPD_ENTRY;
        end else begin
            kind = UPD_NONE;
        end
    end

    // Output stage: register strobes, the target and the new state value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o          <= 1'b0;
            redirect_o      <= 1'b0;
            state_we_o      <= 1'b0;
            redirect_addr_o <= '0;
            state_new_o     <= '0;
        end else begin
            take_o     <= (kind == UPD_ENTRY);
            redirect_o <= (kind != UPD_NONE);
            state_we_o <= (kind != UPD_NONE);
            if (kind == UPD_ENTRY) begin
                redirect_addr_o <= vector;
                state_new_o     <= entry_state;
            end else if (kind == UPD_RETURN) begin
                redirect_addr_o <= save_pc_o;
                state_new_o     <= return_state;
            end
        end
    end

    AST_TAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(state_i[IX_EE]) && $past(irq_i) && $past(boundary_i))); // R1
    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R8
    AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (redirect_addr_o[19:0] == 20'h00500)); // R3
    AST_SAVE_PC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (save_pc_o == $past(next_pc_i))); // R4
    AST_SAVE_STATE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (save_state_o == {16'h0, $past(state_i[15:0])})); // R5
    AST_LE_FROM_ILE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (state_we_o && state_new_o[IX_LE] == $past(state_i[IX_ILE]))); // R6
    AST_RETURN_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rfi_i) |-> (!take_o && redirect_o && state_we_o)); // R9

endmodule

// File: tb/xirq_entry_ctrl_tb_top.sv
// Bench: a table of vectors walked by one loop, then directed tests for
// reset, back-to-back blocking, return and priority.
module xirq_entry_ctrl_tb_top;

    typedef struct packed {
        logic        irq;
        logic        bnd;
        logic [31:0] st;
        logic [31:0] pc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h0000_8000, 32'h0000_0100},  // plain entry, low base
        '{1'b1, 1'b1, 32'h0000_0000, 32'h0000_0200},  // disabled
        '{1'b1, 1'b0, 32'h0000_8000, 32'h0000_0300},  // no boundary
        '{1'b0, 1'b1, 32'h0000_8000, 32'h0000_0400},  // no request
        '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h8000_0004},  // all ones, high base
        '{1'b1, 1'b1, 32'h1234_9A5E, 32'hCAFE_0008},  // mixed, prefix set
        '{1'b1, 1'b1, 32'h0000_8001, 32'h0000_1000},  // LE set, ILE clear
        '{1'b1, 1'b1, 32'hA5A7_F0BF, 32'h0BAD_F00C}   // ILE set, ME kept
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_i, boundary_i, rfi_i;
    logic [31:0] state_i, next_pc_i;
    logic        take_o, redirect_o, state_we_o;
    logic [31:0] redirect_addr_o, state_new_o, save_pc_o, save_state_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xirq_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .boundary_i(boundary_i),
        .rfi_i(rfi_i), .state_i(state_i), .next_pc_i(next_pc_i),
        .take_o(take_o), .redirect_o(redirect_o),
        .redirect_addr_o(redirect_addr_o), .state_we_o(state_we_o),
        .state_new_o(state_new_o), .save_pc_o(save_pc_o),
        .save_state_o(save_state_o)
    );

    // Expected entry state derived from R6 and R7.
    function automatic logic [31:0] exp_entry(input logic [31:0] s);
        logic [31:0] r;
        r = s & ~32'h0006_EF33;
        r[0] = s[16];
        return r;
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] s);
        return s[6] ? 32'hFFF0_0500 : 32'h0000_0500;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic irq, input logic bnd, input logic rfi,
                         input logic [31:0] st, input logic [31:0] pc);
        @(negedge clk);
        irq_i = irq; boundary_i = bnd; rfi_i = rfi; state_i = st; next_pc_i = pc;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    initial begin
        logic [31:0] e_pc, e_st, x_st;
        logic        hit;
        rst_n = 1'b0; irq_i = 0; boundary_i = 0; rfi_i = 0; state_i = 0; next_pc_i = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 take", {31'b0, take_o}, 32'h0);
        chk("R10 redirect", {31'b0, redirect_o}, 32'h0);
        chk("R10 state_we", {31'b0, state_we_o}, 32'h0);
        chk("R10 addr", redirect_addr_o, 32'h0);
        chk("R10 state_new", state_new_o, 32'h0);
        chk("R10 save_pc", save_pc_o, 32'h0);
        chk("R10 save_state", save_state_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        e_pc = 32'h0; e_st = 32'h0;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].irq, VECS[i].bnd, 1'b0, VECS[i].st, VECS[i].pc);
            hit = VECS[i].irq & VECS[i].bnd & VECS[i].st[15];
            if (hit) begin
                e_pc = VECS[i].pc;
                e_st = {16'h0, VECS[i].st[15:0]};
                chk("R3 take", {31'b0, take_o}, 32'h1);
                chk("R3 redirect", {31'b0, redirect_o}, 32'h1);
                chk("R3 vector", redirect_addr_o, exp_vec(VECS[i].st));
                chk("R6 state_we", {31'b0, state_we_o}, 32'h1);
                chk("R6 R7 new state", state_new_o, exp_entry(VECS[i].st));
            end else begin
                chk("R1 R2 no take", {31'b0, take_o}, 32'h0);
                chk("R1 R2 no write", {31'b0, state_we_o}, 32'h0);
            end
            chk("R4 save_pc", save_pc_o, e_pc);
            chk("R5 save_state", save_state_o, e_st);
            idle();
            chk("R8 single pulse", {31'b0, take_o}, 32'h0);
        end

        // R2: a request pulse away from the boundary is not remembered.
        drive(1'b1, 1'b0, 1'b0, 32'h0000_8000, 32'h10);
        drive(1'b0, 1'b1, 1'b0, 32'h0000_8000, 32'h14);
        chk("R2 not latched", {31'b0, take_o}, 32'h0);
        idle();

        // R8: a stale enable in the cycle after an entry is blocked.
        drive(1'b1, 1'b1, 1'b0, 32'h0001_8040, 32'h2000);
        chk("R8 first take", {31'b0, take_o}, 32'h1);
        drive(1'b1, 1'b1, 1'b0, 32'h0001_8040, 32'h2004);
        chk("R8 blocked", {31'b0, take_o}, 32'h0);
        drive(1'b1, 1'b1, 1'b0, 32'h0001_8040, 32'h2008);
        chk("R8 still blocked", {31'b0, take_o}, 32'h0);
        chk("R8 save_pc held", save_pc_o, 32'h2000);
        drive(1'b1, 1'b1, 1'b0, 32'h0001_0040, 32'h200C);  // enable seen low
        chk("R1 disabled", {31'b0, take_o}, 32'h0);
        drive(1'b1, 1'b1, 1'b0, 32'h0001_8040, 32'h2010);
        chk("R8 rearmed", {31'b0, take_o}, 32'h1);
        chk("R4 rearm pc", save_pc_o, 32'h2010);
        idle();

        // R9: return restores the low half and jumps to the saved address.
        x_st = 32'h0000_C3A5;
        drive(1'b0, 1'b0, 1'b1, 32'h5A5A_0000, 32'h0);
        chk("R9 take low", {31'b0, take_o}, 32'h0);
        chk("R9 redirect", {31'b0, redirect_o}, 32'h1);
        chk("R9 addr", redirect_addr_o, 32'h2010);
        chk("R9 state_we", {31'b0, state_we_o}, 32'h1);
        chk("R9 state", state_new_o, {16'h5A5A, 16'h8040});
        idle();

        // R9: a return wins over a simultaneous request.
        drive(1'b1, 1'b1, 1'b1, 32'h0000_8000 | x_st, 32'h3000);
        chk("R9 priority take", {31'b0, take_o}, 32'h0);
        chk("R9 priority addr", redirect_addr_o, 32'h2010);
        chk("R9 save_pc kept", save_pc_o, 32'h2010);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule